// File: doc/BRIEF.md
# Multi-Mode Multiplier with Cycle Timing

This unit is the multiply stage of a small 16-bit coprocessor. One request selects between two groups. The narrow group multiplies the low bytes of two words into a 16-bit product. It can treat the bytes as signed or unsigned, and it can take the second operand from a register or from a 4-bit immediate. The wide group is a signed 16×16 fractional multiply. It returns the upper product word and puts bit 15 of the product into carry. A long variant of the wide group also delivers the lower product word for a fixed low-word register.

Operand fetch and register write-back belong to the surrounding core. The core presents the operands, the two prefix mode bits (`alt1`, `alt2`), the multiplier-speed configuration bit and the core clock-select bit, then raises `start`.

The unit answers one cycle later with a `done` pulse, the results and the flags. It then holds `busy` for as many extra wait cycles as the mode and clocking demand. The core stalls on `busy`. Any request made while `busy` is high is dropped.

Top module: `mmul_unit`

## Requirements
- R1: Narrow group (`op_wide`=0) with `alt1`=0 multiplies bits 7:0 of `src` and bits 7:0 of the second operand as two's-complement bytes. The 16-bit product appears on `res_hi`.
- R2: Narrow group with `alt1`=1 multiplies the same bytes as unsigned values into a 16-bit product on `res_hi`.
- R3: In the narrow group, `alt2`=1 makes the second operand the zero-extended `imm` (0 to 15), and `opnd_reg` has no effect. In the wide group, `alt2` has no effect.
- R4: A narrow operation sets `flag_s` to bit 15 of the product and sets `flag_z` when the product is zero. It leaves `flag_cy` and `res_lo` at their previous values.
- R5: Wide group (`op_wide`=1) multiplies signed `src` by signed `fix_reg` into a 32-bit product. It places product bits 31:16 on `res_hi` and bit 15 in `flag_cy`. It sets `flag_s` from bit 15 of `res_hi` and sets `flag_z` when `res_hi` is zero.
- R6: Wide group with `alt1`=1 (long form) places product bits 15:0 on `res_lo` and raises `lo_we` together with `done`. With `alt1`=0, `res_lo` holds and `lo_we` stays low.
- R7: Narrow wait cycles are 0 when `speed_fast`=1. When `speed_fast`=0 they are 1 if `clk_fast`=1 and 2 if `clk_fast`=0.
- R8: Wide wait cycles are 3 when `speed_fast`=1 and 7 when `speed_fast`=0. Both counts double when `clk_fast`=0.
- R9: A request is taken at a rising edge where `start`=1 and `busy`=0. From that edge on, `done` is high for exactly one cycle with the new results, and `busy` is high for exactly the wait count of cycles.
- R10: While `busy` is high, `start` is ignored: no `done`, and all results and flags hold.
- R11: After reset, all results and flags are zero, and `done`, `lo_we` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply |
| op_wide | input | 1 | 0 = 8×8 group, 1 = 16×16 fractional group |
| alt1 | input | 1 | Narrow: unsigned; wide: long form |
| alt2 | input | 1 | Narrow: immediate second operand |
| speed_fast | input | 1 | Multiplier speed configuration (1 = fast) |
| clk_fast | input | 1 | Core clock select (1 = fast clock) |
| src | input | 16 | Source operand |
| opnd_reg | input | 16 | Register second operand (narrow group) |
| imm | input | 4 | Immediate second operand |
| fix_reg | input | 16 | Fixed multiplicand register (wide group) |
| res_hi | output | 16 | Destination result word |
| res_lo | output | 16 | Low product word (long form) |
| lo_we | output | 1 | Low word valid this cycle |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_cy | output | 1 | Carry flag |
| done | output | 1 | Result valid pulse |
| busy | output | 1 | Stall while extra wait cycles run |

## Verification
The assertions assume that the speed and clock-select bits are stable while a request is being taken, and that every input is a known value at each sampled edge. The bench drives every input at the falling edge and keeps it steady through the next rising edge. It raises `start` only in the cycle that opens a request, except when it deliberately repeats `start` with changed operands to probe the stall. Random operands are mixed with the extreme words 0x8000 and 0xFFFF and with both byte extremes.

// File: rtl/mmul_unit.sv
module mmul_unit #(
  parameter int WORD           = 16,
  parameter int IMMW           = 4,
  parameter int NARROW_WAIT    = 1,
  parameter int FRAC_FAST_WAIT = 3,
  parameter int FRAC_SLOW_WAIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_wide,
  input  logic            alt1,
  input  logic            alt2,
  input  logic            speed_fast,
  input  logic            clk_fast,
  input  logic [WORD-1:0] src,
  input  logic [WORD-1:0] opnd_reg,
  input  logic [IMMW-1:0] imm,
  input  logic [WORD-1:0] fix_reg,
  output logic [WORD-1:0] res_hi,
  output logic [WORD-1:0] res_lo,
  output logic            lo_we,
  output logic            flag_s,
  output logic            flag_z,
  output logic            flag_cy,
  output logic            done,
  output logic            busy
);
  localparam int HALF = WORD / 2;
  localparam int CW   = $clog2(2 * FRAC_SLOW_WAIT + 1);

  logic [CW-1:0]          cnt;
  logic                   wide_q;
  logic                   accept;
  logic [WORD-1:0]        opnd;
  logic signed [WORD-1:0] sprod;
  logic [WORD-1:0]        uprod;
  logic [WORD-1:0]        nres;
  logic signed [2*WORD-1:0] wprod;
  logic [CW-1:0]          wait_n, wait_w;

  assign busy   = (cnt != '0);
  assign accept = start && !busy;
  assign opnd   = alt2 ? WORD'(imm) : opnd_reg;
  assign sprod  = $signed(src[HALF-1:0]) * $signed(opnd[HALF-1:0]);
  assign uprod  = WORD'(src[HALF-1:0]) * WORD'(opnd[HALF-1:0]);
  assign nres   = alt1 ? uprod : sprod;
  assign wprod  = $signed({{WORD{src[WORD-1]}}, src}) * $signed({{WORD{fix_reg[WORD-1]}}, fix_reg});
  assign wait_n = speed_fast ? '0 : (clk_fast ? CW'(NARROW_WAIT) : CW'(2 * NARROW_WAIT));
  assign wait_w = (speed_fast ? CW'(FRAC_FAST_WAIT) : CW'(FRAC_SLOW_WAIT)) << (clk_fast ? 0 : 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      wide_q  <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
      lo_we   <= 1'b0;
      flag_s  <= 1'b0;
      flag_z  <= 1'b0;
      flag_cy <= 1'b0;
      done    <= 1'b0;
    end else if (accept) begin
      done   <= 1'b1;
      wide_q <= op_wide;
      if (op_wide) begin
        res_hi  <= wprod[2*WORD-1:WORD];
        flag_s  <= wprod[2*WORD-1];
        flag_z  <= (wprod[2*WORD-1:WORD] == '0);
        flag_cy <= wprod[WORD-1];
        lo_we   <= alt1;
        if (alt1) res_lo <= wprod[WORD-1:0];
        cnt <= wait_w;
      end else begin
        res_hi <= nres;
        flag_s <= nres[WORD-1];
        flag_z <= (nres == '0);
        lo_we  <= 1'b0;
        cnt    <= wait_n;
      end
    end else begin
      done  <= 1'b0;
      lo_we <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(res_hi) && $stable(res_lo) && $stable(flag_cy) && !done);

  a_r9_done_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start) && !$past(busy));

  a_r4_narrow_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wide_q |-> flag_cy == $past(flag_cy) && res_lo == $past(res_lo));

  a_r6_low_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_we |-> $stable(res_lo));

  a_r7_fast_narrow_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wide_q && $past(speed_fast) |-> !busy);

  a_r8_wide_always_waits: assert property (@(posedge clk) disable iff (!rst_n)
    done && wide_q |-> busy);
endmodule

// File: tb/mmul_unit_bench.sv
module mmul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_wide = 1'b0, alt1 = 1'b0, alt2 = 1'b0;
  logic        speed_fast = 1'b0, clk_fast = 1'b0;
  logic [15:0] src = '0, opnd_reg = '0, fix_reg = '0;
  logic [3:0]  imm = '0;
  logic [15:0] res_hi, res_lo;
  logic        lo_we, flag_s, flag_z, flag_cy, done, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] m_lo = '0;
  logic        m_cy = 1'b0;

  always #5 clk = ~clk;

  mmul_unit u_mmul_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_wide(op_wide), .alt1(alt1), .alt2(alt2),
    .speed_fast(speed_fast), .clk_fast(clk_fast), .src(src), .opnd_reg(opnd_reg), .imm(imm),
    .fix_reg(fix_reg), .res_hi(res_hi), .res_lo(res_lo), .lo_we(lo_we), .flag_s(flag_s),
    .flag_z(flag_z), .flag_cy(flag_cy), .done(done), .busy(busy));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] narrow_ref(logic a1, logic a2, logic [15:0] s, logic [15:0] r, logic [3:0] i);
    logic [7:0] b;
    logic signed [7:0] sa, sb;
    int p;
    b  = a2 ? {4'b0, i} : r[7:0];
    sa = s[7:0];
    sb = b;
    p  = a1 ? (int'(s[7:0]) * int'(b)) : (int'(sa) * int'(sb));
    return p[15:0];
  endfunction

  function automatic logic [31:0] wide_ref(logic [15:0] s, logic [15:0] f);
    logic signed [15:0] ss, fs;
    longint p;
    ss = s;
    fs = f;
    p  = longint'(ss) * longint'(fs);
    return p[31:0];
  endfunction

  function automatic int wait_ref(logic w, logic sf, logic cf);
    if (w) return (sf ? 3 : 7) * (cf ? 1 : 2);
    return sf ? 0 : (cf ? 1 : 2);
  endfunction

  task automatic run_op(input logic w, input logic a1, input logic a2, input logic sf, input logic cf,
                        input logic [15:0] s, input logic [15:0] r, input logic [3:0] i,
                        input logic [15:0] f, input bit poke);
    logic [15:0] e_hi;
    logic [31:0] p;
    logic e_s, e_z;
    int e_wait, n;
    bit extra_done;
    string tg;
    @(negedge clk);
    op_wide = w; alt1 = a1; alt2 = a2; speed_fast = sf; clk_fast = cf;
    src = s; opnd_reg = r; imm = i; fix_reg = f; start = 1'b1;
    if (w) begin
      p = wide_ref(s, f);
      e_hi = p[31:16];
      m_cy = p[15];
      if (a1) m_lo = p[15:0];
      tg = a1 ? "R6" : "R5";
    end else begin
      e_hi = narrow_ref(a1, a2, s, r, i);
      tg = a2 ? "R3" : (a1 ? "R2" : "R1");
    end
    e_s = e_hi[15];
    e_z = (e_hi == 16'h0);
    e_wait = wait_ref(w, sf, cf);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(res_hi == e_hi, tg, res_hi, e_hi);
    chk(flag_s == e_s && flag_z == e_z, w ? "R5 sign/zero" : "R4 sign/zero", {flag_s, flag_z}, {e_s, e_z});
    chk(flag_cy == m_cy, w ? "R5 carry" : "R4 carry held", flag_cy, m_cy);
    chk(res_lo == m_lo, w ? "R6 low word" : "R4 low word held", res_lo, m_lo);
    chk(lo_we == (w & a1), "R6 lo_we", lo_we, w & a1);
    n = 0;
    extra_done = 1'b0;
    while (busy && n < 40) begin
      n++;
      if (poke) begin
        start = 1'b1;
        src = ~s; opnd_reg = ~r; fix_reg = ~f; imm = ~i;
      end
      @(negedge clk);
      if (done) extra_done = 1'b1;
      start = 1'b0;
    end
    chk(n == e_wait, w ? "R8 wait count" : "R7 wait count", n, e_wait);
    if (poke) begin
      chk(!extra_done, "R10 no done while busy", extra_done, 0);
      chk(res_hi == e_hi && flag_cy == m_cy && res_lo == m_lo, "R10 hold", res_hi, e_hi);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk(res_hi == 0 && res_lo == 0 && !flag_s && !flag_z && !flag_cy && !done && !lo_we && !busy,
        "R11 reset state", {res_hi, res_lo}, 0);
    rst_n = 1'b1;
    run_op(0, 0, 0, 1, 1, 16'h1280, 16'h3480, 4'h0, 16'h0, 0);
    run_op(0, 1, 0, 1, 1, 16'h00FF, 16'hAAFF, 4'h0, 16'h0, 0);
    run_op(0, 0, 0, 0, 1, 16'h00FF, 16'h0001, 4'h0, 16'h0, 0);
    run_op(0, 0, 1, 0, 0, 16'h00F0, 16'hFFFF, 4'hF, 16'h0, 0);
    run_op(0, 1, 1, 1, 0, 16'h00FF, 16'h1234, 4'h0, 16'h0, 0);
    run_op(1, 0, 0, 1, 1, 16'h8000, 16'h0, 4'h0, 16'h8000, 0);
    run_op(1, 1, 0, 0, 0, 16'hFFFF, 16'h0, 4'h0, 16'hFFFF, 0);
    run_op(1, 1, 1, 1, 0, 16'h8000, 16'h0, 4'h0, 16'h7FFF, 0);
    run_op(1, 0, 1, 0, 1, 16'h7FFF, 16'h5555, 4'h3, 16'h8000, 1);
    run_op(0, 0, 0, 0, 0, 16'h0080, 16'h0080, 4'h0, 16'h0, 1);
    for (int k = 0; k < 400; k++) begin
      logic [15:0] rs, rr, rf;
      rs = 16'($urandom);
      rr = 16'($urandom);
      rf = 16'($urandom);
      if (k % 17 == 0) rs = 16'h8000;
      if (k % 19 == 0) rf = 16'hFFFF;
      run_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             rs, rr, 4'($urandom), rf, (k % 5) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule